// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block turns an asynchronous serial line into parallel characters. A clock enable running at sixteen times the bit rate paces the work. Three samples are taken around the centre of every bit, and the bit value is whatever at least two of them agree on. A falling edge on the idle line starts a character. The start bit is checked again at its centre, so a short low glitch sends the receiver back to idle and no character is produced.

For every character the block gives a one-cycle valid strobe. With it come the assembled data byte and three error flags: parity, framing and break.

- **Character length and parity.** These are set by static configuration inputs. The block latches them at the start edge of each character.
- **Stop bit.** The character is delivered at the centre of the stop bit. The receiver can then catch a start edge that follows at once.
- **Break.** A line held low through a whole character gives one break character. After that the receiver waits for the line to go high again.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset `rx_valid` is 0, and `rx_data` and all three error flags read 0.
- R2: Data bits are received least significant bit first. With an 8-bit length (`len_sel` = 2'b11) and no parity, the byte is delivered intact with no error flags.
- R3: The `len_sel` input selects the data length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Bits of `rx_data` above the selected length are 0.
- R4: With `par_en`=1 and `par_stick`=0, one parity bit follows the data bits. `par_even`=1 expects an even total count of ones over data and parity. `par_even`=0 expects an odd total. `rx_perr` is set when the received parity bit does not match.
- R5: With `par_en`=1 and `par_stick`=1, the parity bit is expected to be the inverse of `par_even`: 0 when `par_even`=1 and 1 when `par_even`=0. `rx_perr` is set when it differs.
- R6: Each bit is decided by the majority of samples taken on oversampling ticks 7, 8 and 9 of its 16-tick period. A single-tick disturbance at the bit centre does not change the received bit.
- R7: A low pulse that is no longer low at the centre of the start bit produces no character. The next valid character is then received normally.
- R8: `rx_ferr` is set when the stop bit samples low. The data bits are still delivered.
- R9: A line held low through the data, parity and stop positions gives exactly one character. That character has `rx_data`=0, `rx_brk`=1, `rx_ferr`=1 and `rx_perr`=0. No further character is produced until the line has returned high.
- R10: `rx_valid` is high for exactly one clock per received character. `rx_data` and the flags hold their values until the next character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Asynchronous serial input, idle high |
| len_sel | input | 2 | Data length select (5 to 8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select (odd when 0) |
| par_stick | input | 1 | Fixed-value parity select |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| rx_data | output | 8 | Received character, zero-extended |
| rx_perr | output | 1 | Parity error for this character |
| rx_ferr | output | 1 | Framing error for this character |
| rx_brk | output | 1 | Break detected for this character |

## Verification
The hardest case to reach from the ports is a disturbance that hits exactly one of the three centre samples of a bit. The timing from an edge on `rxd` to a sample depends on the input synchronizer and on where the start edge was detected. The stimulus holds `tick16` high continuously, so one bit lasts exactly 16 clocks. It then flips the line for one clock at the centre offset of a chosen bit, in both polarities. A second hard case is the line falling again right after a failed stop bit. The framing test leaves the stop low, so the receiver sees a false start that it must reject without producing a second character.

// File: rtl/uart_vote_rx_pkg.sv
package uart_vote_rx_pkg;

    localparam int DATA_MAX = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } rx_cfg_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                perr;
        logic                ferr;
        logic                brk;
    } rx_char_t;

    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic expected_parity(input rx_cfg_t cfg, input logic ones_odd);
        if (cfg.par_stick)
            return ~cfg.par_even;
        else if (cfg.par_even)
            return ones_odd;
        else
            return ~ones_odd;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[g] <= 1'b1;
                else if (g == 0)
                    chain[g] <= din;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_vote.sv
module rx_bit_vote #(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          line,
    input  logic [CW-1:0] phase,
    output logic          vote,
    output logic          vote_ready
);
    localparam logic [CW-1:0] MID = CW'(OSR / 2);

    logic s_early, s_mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_early <= 1'b1;
            s_mid   <= 1'b1;
        end else if (tick) begin
            if (phase == MID - 1'b1) s_early <= line;
            if (phase == MID)        s_mid   <= line;
        end
    end

    assign vote       = (s_early & s_mid) | (s_early & line) | (s_mid & line);
    assign vote_ready = tick && (phase == MID + 1'b1);

    // R6: two agreeing samples outvote the third
    a_r6_two_agree: assert property (@(posedge clk) disable iff (rst)
        (vote_ready && s_early == s_mid) |-> (vote == s_early));
endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
    import uart_vote_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          line,
    input  rx_cfg_t       cfg,
    input  logic          vote,
    input  logic          vote_ready,
    output logic [CW-1:0] phase,
    output logic          out_valid,
    output rx_char_t      out_char
);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_e           state;
    rx_cfg_t             cfg_q;
    logic [2:0]          bit_idx;
    logic [DATA_MAX-1:0] shreg;
    logic                ones_odd;
    logic                all_low;
    logic                pbit;
    logic                last_data;
    logic                brk_now;

    assign last_data = ({1'b0, bit_idx} == data_bits(cfg_q.len) - 4'd1);
    assign brk_now   = all_low && !vote;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= '0;
            cfg_q     <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            ones_odd  <= 1'b0;
            all_low   <= 1'b0;
            pbit      <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state    <= ST_START;
                            phase    <= CW'(1);
                            cfg_q    <= cfg;
                            bit_idx  <= '0;
                            shreg    <= '0;
                            ones_odd <= 1'b0;
                            all_low  <= 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (line) state <= ST_IDLE;
                    end
                    default: begin
                        phase <= (phase == LAST) ? '0 : phase + 1'b1;
                        if (vote_ready) begin
                            case (state)
                                ST_START: if (vote) state <= ST_IDLE;
                                ST_DATA: begin
                                    shreg[bit_idx] <= vote;
                                    ones_odd       <= ones_odd ^ vote;
                                    all_low        <= all_low & ~vote;
                                end
                                ST_PARITY: begin
                                    pbit    <= vote;
                                    all_low <= all_low & ~vote;
                                end
                                ST_STOP: begin
                                    out_valid     <= 1'b1;
                                    out_char.data <= shreg;
                                    out_char.ferr <= !vote;
                                    out_char.brk  <= brk_now;
                                    out_char.perr <= !brk_now && cfg_q.par_en &&
                                                     (pbit != expected_parity(cfg_q, ones_odd));
                                    state         <= brk_now ? ST_HOLD : ST_IDLE;
                                end
                                default: ;
                            endcase
                        end else if (phase == LAST) begin
                            case (state)
                                ST_START: state <= ST_DATA;
                                ST_DATA: begin
                                    if (last_data)
                                        state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                                    else
                                        bit_idx <= bit_idx + 1'b1;
                                end
                                ST_PARITY: state <= ST_STOP;
                                default: ;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    // R10: strobe lasts one cycle
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3: bits above the latched length stay clear
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_char.data >> data_bits(cfg_q.len)) == '0));

    // R9: a break character is all-zero and framed wrong, without parity error
    a_r9_break_shape: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_char.brk) |-> (out_char.ferr && out_char.data == '0 && !out_char.perr));

    // R9: no character while waiting for the line to rise
    a_r9_hold_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !out_valid) |=> !out_valid);

    // R7: a start bit that votes high abandons the character
    a_r7_false_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && vote_ready && vote) |=> (state == ST_IDLE && !out_valid));
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
    import uart_vote_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_brk
);
    localparam int CW = $clog2(OSR);

    logic          line_s;
    logic          vote, vote_ready;
    logic [CW-1:0] phase;
    rx_cfg_t       cfg;
    rx_char_t      chr;

    assign cfg = '{len: len_sel, par_en: par_en, par_even: par_even, par_stick: par_stick};

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
    );

    rx_bit_vote #(.OSR(OSR), .CW(CW)) u_vote (
        .clk(clk), .rst(rst), .tick(tick16), .line(line_s), .phase(phase),
        .vote(vote), .vote_ready(vote_ready)
    );

    rx_frame_ctl #(.OSR(OSR), .CW(CW)) u_ctl (
        .clk(clk), .rst(rst), .tick(tick16), .line(line_s), .cfg(cfg),
        .vote(vote), .vote_ready(vote_ready), .phase(phase),
        .out_valid(rx_valid), .out_char(chr)
    );

    assign rx_data = chr.data;
    assign rx_perr = chr.perr;
    assign rx_ferr = chr.ferr;
    assign rx_brk  = chr.brk;

    // R9: a break always carries a framing error
    a_r9_break_framed: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_brk) |-> rx_ferr);
endmodule

// File: tb/uart_vote_rx_test.sv
module uart_vote_rx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] len_sel = 2'b11;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_brk;

    int checks = 0;
    int errors = 0;
    int got_n  = 0;
    logic [7:0] got_data;
    logic got_p, got_f, got_b;
    logic prev_valid = 1'b0;
    int   double_pulses = 0;

    always #5 clk = ~clk;

    uart_vote_rx uut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .len_sel(len_sel), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid && prev_valid) double_pulses++;
            if (rx_valid) begin
                got_n++;
                got_data = rx_data;
                got_p = rx_perr; got_f = rx_ferr; got_b = rx_brk;
            end
            prev_valid = rx_valid;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input bit glitch);
        for (int c = 0; c < 16; c++) begin
            rxd = (glitch && c == 9) ? ~v : v;
            @(negedge clk);
        end
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit pen,
                        input logic pval, input logic stopv, input int gbit);
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i], gbit == i);
        if (pen) drive_bit(pval, 1'b0);
        drive_bit(stopv, 1'b0);
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    function automatic logic par_of(input logic [7:0] d, input int nb,
                                    input bit even, input bit stick);
        logic x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        if (stick) return ~even;
        return even ? x : ~x;
    endfunction

    task automatic expect_char(input string tag, input int n0, input logic [7:0] d,
                               input logic p, input logic f, input logic b);
        chk(got_n == n0 + 1, {tag, " count"}, got_n - n0, 1);
        chk(got_data == d, {tag, " data"}, got_data, d);
        chk({got_p, got_f, got_b} == {p, f, b}, {tag, " flags"}, {got_p, got_f, got_b}, {p, f, b});
    endtask

    task automatic t_reset;
        chk(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
        chk({rx_data, rx_perr, rx_ferr, rx_brk} == 11'd0, "R1 outputs",
            {rx_data, rx_perr, rx_ferr, rx_brk}, 0);
    endtask

    task automatic t_8n1;
        int n0;
        len_sel = 2'b11; par_en = 1'b0;
        n0 = got_n; send(8'hA5, 8, 0, 0, 1, -1); expect_char("R2 A5", n0, 8'hA5, 0, 0, 0);
        n0 = got_n; send(8'h3C, 8, 0, 0, 1, -1); expect_char("R2 3C", n0, 8'h3C, 0, 0, 0);
        n0 = got_n; send(8'h01, 8, 0, 0, 1, -1); expect_char("R2 lsb first", n0, 8'h01, 0, 0, 0);
    endtask

    task automatic t_lengths;
        int n0;
        par_en = 1'b0;
        len_sel = 2'b00; n0 = got_n; send(8'h15, 5, 0, 0, 1, -1);
        expect_char("R3 len5", n0, 8'h15, 0, 0, 0);
        len_sel = 2'b01; n0 = got_n; send(8'h2A, 6, 0, 0, 1, -1);
        expect_char("R3 len6", n0, 8'h2A, 0, 0, 0);
        len_sel = 2'b10; n0 = got_n; send(8'h55, 7, 0, 0, 1, -1);
        expect_char("R3 len7", n0, 8'h55, 0, 0, 0);
        len_sel = 2'b11;
    endtask

    task automatic t_parity;
        int n0;
        logic p;
        len_sel = 2'b11; par_en = 1'b1; par_stick = 1'b0;
        par_even = 1'b1; p = par_of(8'h5B, 8, 1, 0);
        n0 = got_n; send(8'h5B, 8, 1, p, 1, -1);  expect_char("R4 even ok", n0, 8'h5B, 0, 0, 0);
        n0 = got_n; send(8'h5B, 8, 1, ~p, 1, -1); expect_char("R4 even bad", n0, 8'h5B, 1, 0, 0);
        par_even = 1'b0; p = par_of(8'hC4, 8, 0, 0);
        n0 = got_n; send(8'hC4, 8, 1, p, 1, -1);  expect_char("R4 odd ok", n0, 8'hC4, 0, 0, 0);
        n0 = got_n; send(8'hC4, 8, 1, ~p, 1, -1); expect_char("R4 odd bad", n0, 8'hC4, 1, 0, 0);
        len_sel = 2'b01; p = par_of(8'h31, 6, 0, 0);
        n0 = got_n; send(8'h31, 6, 1, p, 1, -1);  expect_char("R4 odd len6", n0, 8'h31, 0, 0, 0);
        len_sel = 2'b11; par_en = 1'b0;
    endtask

    task automatic t_stick;
        int n0;
        par_en = 1'b1; par_stick = 1'b1;
        par_even = 1'b1;
        n0 = got_n; send(8'h07, 8, 1, 1'b0, 1, -1); expect_char("R5 stick0 ok", n0, 8'h07, 0, 0, 0);
        n0 = got_n; send(8'h07, 8, 1, 1'b1, 1, -1); expect_char("R5 stick0 bad", n0, 8'h07, 1, 0, 0);
        par_even = 1'b0;
        n0 = got_n; send(8'h07, 8, 1, 1'b1, 1, -1); expect_char("R5 stick1 ok", n0, 8'h07, 0, 0, 0);
        n0 = got_n; send(8'h07, 8, 1, 1'b0, 1, -1); expect_char("R5 stick1 bad", n0, 8'h07, 1, 0, 0);
        par_en = 1'b0; par_stick = 1'b0;
    endtask

    task automatic t_glitch;
        int n0;
        len_sel = 2'b11; par_en = 1'b0;
        n0 = got_n; send(8'h00, 8, 0, 0, 1, 2); expect_char("R6 low glitch", n0, 8'h00, 0, 0, 0);
        n0 = got_n; send(8'hFF, 8, 0, 0, 1, 5); expect_char("R6 high glitch", n0, 8'hFF, 0, 0, 0);
    endtask

    task automatic t_false_start;
        int n0;
        n0 = got_n;
        rxd = 1'b0; repeat (4) @(negedge clk);
        rxd = 1'b1; repeat (200) @(negedge clk);
        chk(got_n == n0, "R7 no char", got_n - n0, 0);
        n0 = got_n; send(8'h96, 8, 0, 0, 1, -1); expect_char("R7 recover", n0, 8'h96, 0, 0, 0);
    endtask

    task automatic t_frame;
        int n0;
        n0 = got_n; send(8'h81, 8, 0, 0, 0, -1);
        repeat (200) @(negedge clk);
        expect_char("R8 stop low", n0, 8'h81, 0, 1, 0);
    endtask

    task automatic t_break;
        int n0;
        n0 = got_n;
        rxd = 1'b0; repeat (16 * 20) @(negedge clk);
        expect_char("R9 break", n0, 8'h00, 0, 1, 1);
        rxd = 1'b1; repeat (40) @(negedge clk);
        chk(got_n == n0 + 1, "R9 single", got_n - n0, 1);
        n0 = got_n; send(8'h5A, 8, 0, 0, 1, -1); expect_char("R9 after break", n0, 8'h5A, 0, 0, 0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        repeat (20) @(negedge clk);
        t_8n1();
        t_lengths();
        t_parity();
        t_stick();
        t_glitch();
        t_false_start();
        t_frame();
        t_break();
        chk(double_pulses == 0, "R10 pulse width", double_pulses, 0);
        chk(got_data == 8'h5A, "R10 data held", got_data, 8'h5A);
        repeat (50) @(negedge clk);
        chk(rx_data == 8'h5A && !rx_valid, "R10 hold after idle", rx_data, 8'h5A);
        finish_run();
    end
endmodule